// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Idle-State Insertion

This block turns access requests from an internal master into cycles on a shared external data bus. The bus serves several address areas. Each request names a target area and an address, and says whether it is a read or a write and whether it is a full access or a burst beat. A full access has an address state and one data state, followed by any wait states. A burst beat is a single data state that continues a burst ROM read.

Some devices take a long time to release the data bus after a read, so they can collide with whatever drives the bus next. To prevent this, the sequencer keeps a registered record of the last completed cycle: whether it was a read, and which area it addressed. Using that record, it places one idle bus state in front of a new cycle in two cases. The first is a read that follows a read to a different area. The second is a write that follows a read. Each case has its own enable input.

Wait states can stretch only the data state of a full access. Their number comes from a programmed count or from an external wait input. A burst beat always takes exactly one state.

Top module: `xbus_cycle_seq`

## Requirements
- R1: After reset, no bus strobe, ack or idle indication is active, and the record of the last cycle is cleared. The first access after reset never gets an idle state, even with both enables set.
- R2: With `cfg_rr_idle_en`=1, a read whose area differs from that of a preceding read starts with exactly one state in which `bus_tidle`=1 and no strobe or ack is active. Its address state follows directly.
- R3: Two reads in a row to the same area never get an idle state.
- R4: With `cfg_rr_idle_en`=0, a read to a different area after a read starts with no idle state.
- R5: With `cfg_wr_idle_en`=1, a write that follows a read starts with exactly one idle state. This holds even when request-free cycles lie between the two.
- R6: With `cfg_wr_idle_en`=0, a write that follows a read starts with no idle state.
- R7: A read or a write that follows a write never gets an idle state.
- R8: A full access takes one address state (`bus_as`=1) and then 1+N data states, where N=`cfg_wait_cnt`. `bus_rd` or `bus_wr` is high during each data state.
- R9: `bus_wait` is sampled at the end of every data state of a full access. Each sampled 1 adds one state. If the pin is held for the first K data states, the access has 1+max(N,K) data states.
- R10: A burst beat (`req_burst`=1) is exactly one data state with no address state. It ignores both `bus_wait` and `cfg_wait_cnt`.
- R11: `ack` is high only during the final state of an access. A read captures `bus_din` in that state, and `rd_data` shows the value from the next cycle on. A request may be held high across the ack, with new fields, to start the next access with no gap.
- R12: During a write, `bus_dout` carries `req_wdata` and `bus_dout_en` is high from the address state to the final state. `bus_area` and `bus_addr` carry the request's area and address in every address or data state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request pending; held until ack |
| req_area | input | AREA_W | Target area of the request |
| req_addr | input | ADDR_W | Address within the area |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = burst beat, 0 = full access |
| req_wdata | input | DATA_W | Write data |
| ack | output | 1 | Final state of the current access |
| rd_data | output | DATA_W | Data captured by the last read |
| cfg_rr_idle_en | input | 1 | Enables idle insertion between reads to different areas |
| cfg_wr_idle_en | input | 1 | Enables idle insertion for a write after a read |
| cfg_wait_cnt | input | WAIT_W | Programmed waits for a full access |
| bus_area | output | AREA_W | Area select during an access |
| bus_addr | output | ADDR_W | Address during an access |
| bus_as | output | 1 | Address state strobe |
| bus_rd | output | 1 | Read data strobe |
| bus_wr | output | 1 | Write data strobe |
| bus_dout | output | DATA_W | Write data to the bus |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | DATA_W | Read data from the bus |
| bus_wait | input | 1 | External wait request |
| bus_tidle | output | 1 | Inserted idle state |

## Verification
Two things can land in the same cycle and have to be told apart. One is the idle decision for a new request. The other is the completion of the previous access, which updates the record that the decision reads. The bench provokes this by holding `req` high across each ack with the next request's fields, so a new access begins in the cycle right after the old one ends. Its model predicts, cycle by cycle, whether an idle state leads and how many wait states follow. The second collision is the external wait pin arriving during a programmed wait count, or during a burst beat. The bench checks that the stretch equals the larger of the two for a full access and is zero for a beat.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_TI   = 3'd1,
        PH_T1   = 3'd2,
        PH_T2   = 3'd3,
        PH_TW   = 3'd4,
        PH_TB   = 3'd5
    } phase_e;

    function automatic logic is_data_ph(phase_e p);
        return (p == PH_T2) || (p == PH_TW) || (p == PH_TB);
    endfunction

    function automatic logic is_full_data_ph(phase_e p);
        return (p == PH_T2) || (p == PH_TW);
    endfunction

    function automatic logic is_bus_ph(phase_e p);
        return (p == PH_T1) || is_data_ph(p);
    endfunction

endpackage

// File: rtl/xbus_idle_policy.sv
module xbus_idle_policy #(
    parameter int AREA_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rr_en,
    input  logic              wr_en,
    input  logic              nxt_write,
    input  logic [AREA_W-1:0] nxt_area,
    input  logic              done,
    input  logic              done_write,
    input  logic [AREA_W-1:0] done_area,
    output logic              insert
);
    logic              last_rd;
    logic [AREA_W-1:0] last_area;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_rd   <= 1'b0;
            last_area <= '0;
        end else if (done) begin
            last_rd   <= !done_write;
            last_area <= done_area;
        end
    end

    always_comb begin
        if (!last_rd)
            insert = 1'b0;
        else if (nxt_write)
            insert = wr_en;
        else
            insert = rr_en && (nxt_area != last_area);
    end
endmodule

// File: rtl/xbus_wait_gate.sv
module xbus_wait_gate #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  xbus_pkg::phase_e  ph,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              pin_wait,
    output logic              extend
);
    import xbus_pkg::*;

    logic [WAIT_W-1:0] wleft;

    always_ff @(posedge clk) begin
        if (rst)
            wleft <= '0;
        else if (ph == PH_T1)
            wleft <= cfg_wait;
        else if (is_full_data_ph(ph) && (wleft != '0))
            wleft <= wleft - 1'b1;
    end

    // Burst beats never extend: only full data states consult the waits.
    assign extend = is_full_data_ph(ph) && ((wleft != '0) || pin_wait);
endmodule

// File: rtl/xbus_phase_fsm.sv
module xbus_phase_fsm (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             start_insert,
    input  logic             burst,
    input  logic             extend,
    output xbus_pkg::phase_e ph,
    output logic             at_rest,
    output logic             ack
);
    import xbus_pkg::*;

    phase_e st, nxt;

    assign at_rest = (st == PH_IDLE);

    always_comb begin
        if (at_rest && req)
            ph = start_insert ? PH_TI : (burst ? PH_TB : PH_T1);
        else
            ph = st;
    end

    always_comb begin
        unique case (ph)
            PH_IDLE: nxt = PH_IDLE;
            PH_TI:   nxt = burst ? PH_TB : PH_T1;
            PH_T1:   nxt = PH_T2;
            PH_T2,
            PH_TW:   nxt = extend ? PH_TW : PH_IDLE;
            PH_TB:   nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    assign ack = (ph == PH_TB) || (is_full_data_ph(ph) && !extend);

    always_ff @(posedge clk) begin
        if (rst) st <= PH_IDLE;
        else     st <= nxt;
    end
endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq #(
    parameter int AREA_W = 3,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [AREA_W-1:0] req_area,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_burst,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cfg_rr_idle_en,
    input  logic              cfg_wr_idle_en,
    input  logic [WAIT_W-1:0] cfg_wait_cnt,
    output logic [AREA_W-1:0] bus_area,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_as,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_wait,
    output logic              bus_tidle
);
    import xbus_pkg::*;

    phase_e            eff_ph;
    logic              at_rest, insert, extend;
    logic [AREA_W-1:0] cur_area,  fld_area;
    logic [ADDR_W-1:0] cur_addr,  fld_addr;
    logic [DATA_W-1:0] cur_wdata, fld_wdata;
    logic              cur_write, fld_write;
    logic              cur_burst, fld_burst;

    // Fields come straight from the request while launching, then from the latch.
    assign fld_area  = at_rest ? req_area  : cur_area;
    assign fld_addr  = at_rest ? req_addr  : cur_addr;
    assign fld_wdata = at_rest ? req_wdata : cur_wdata;
    assign fld_write = at_rest ? req_write : cur_write;
    assign fld_burst = at_rest ? req_burst : cur_burst;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_area  <= '0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_write <= 1'b0;
            cur_burst <= 1'b0;
        end else if (at_rest) begin
            cur_area  <= req_area;
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
            cur_write <= req_write;
            cur_burst <= req_burst;
        end
    end

    xbus_idle_policy #(.AREA_W(AREA_W)) u_policy (
        .clk        (clk),
        .rst        (rst),
        .rr_en      (cfg_rr_idle_en),
        .wr_en      (cfg_wr_idle_en),
        .nxt_write  (req_write),
        .nxt_area   (req_area),
        .done       (ack),
        .done_write (fld_write),
        .done_area  (fld_area),
        .insert     (insert)
    );

    xbus_phase_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .start_insert (insert),
        .burst        (fld_burst),
        .extend       (extend),
        .ph           (eff_ph),
        .at_rest      (at_rest),
        .ack          (ack)
    );

    xbus_wait_gate #(.WAIT_W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .ph       (eff_ph),
        .cfg_wait (cfg_wait_cnt),
        .pin_wait (bus_wait),
        .extend   (extend)
    );

    assign bus_tidle   = (eff_ph == PH_TI);
    assign bus_as      = (eff_ph == PH_T1);
    assign bus_rd      = is_data_ph(eff_ph) && !fld_write;
    assign bus_wr      = is_data_ph(eff_ph) &&  fld_write;
    assign bus_area    = is_bus_ph(eff_ph) ? fld_area : '0;
    assign bus_addr    = is_bus_ph(eff_ph) ? fld_addr : '0;
    assign bus_dout    = fld_wdata;
    assign bus_dout_en = is_bus_ph(eff_ph) && fld_write;

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (ack && !fld_write)
            rd_data <= bus_din;
    end
endmodule

// File: rtl/xbus_cycle_seq_chk.sv
module xbus_cycle_seq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input xbus_pkg::phase_e  eff_ph,
    input logic              ack,
    input logic              bus_as,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_tidle,
    input logic              bus_dout_en,
    input logic [DATA_W-1:0] bus_din,
    input logic [DATA_W-1:0] rd_data
);
    import xbus_pkg::*;

    // R2
    tidle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        bus_tidle |-> (!bus_as && !bus_rd && !bus_wr && !ack));

    // R2
    tidle_single_chk: assert property (@(posedge clk) disable iff (rst)
        bus_tidle |=> (!bus_tidle && (bus_as || bus_rd || bus_wr)));

    // R8
    addr_then_data_chk: assert property (@(posedge clk) disable iff (rst)
        bus_as |=> (bus_rd || bus_wr));

    // R11
    addr_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
        bus_as |-> !ack);

    // R10
    beat_single_chk: assert property (@(posedge clk) disable iff (rst)
        (eff_ph == PH_TB) |-> (ack && !bus_as));

    // R11
    rd_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && bus_rd) |=> (rd_data == $past(bus_din)));

    // R12
    wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> bus_dout_en);
endmodule

bind xbus_cycle_seq xbus_cycle_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .eff_ph      (eff_ph),
    .ack         (ack),
    .bus_as      (bus_as),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_tidle   (bus_tidle),
    .bus_dout_en (bus_dout_en),
    .bus_din     (bus_din),
    .rd_data     (rd_data)
);

// File: tb/xbus_cycle_seq_tb_top.sv
module xbus_cycle_seq_tb_top;
    localparam int AREA_W = 3;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int WAIT_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic [AREA_W-1:0] req_area = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_write = 1'b0, req_burst = 1'b0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic ack;
    logic [DATA_W-1:0] rd_data;
    logic cfg_rr_idle_en = 1'b1, cfg_wr_idle_en = 1'b1;
    logic [WAIT_W-1:0] cfg_wait_cnt = '0;
    logic [AREA_W-1:0] bus_area;
    logic [ADDR_W-1:0] bus_addr;
    logic bus_as, bus_rd, bus_wr, bus_dout_en, bus_tidle;
    logic [DATA_W-1:0] bus_dout;
    logic [DATA_W-1:0] bus_din = '0;
    logic bus_wait = 1'b0;

    always #5 clk = ~clk;

    xbus_cycle_seq #(.AREA_W(AREA_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) dut_i (
        .clk(clk), .rst(rst), .req(req), .req_area(req_area), .req_addr(req_addr),
        .req_write(req_write), .req_burst(req_burst), .req_wdata(req_wdata),
        .ack(ack), .rd_data(rd_data), .cfg_rr_idle_en(cfg_rr_idle_en),
        .cfg_wr_idle_en(cfg_wr_idle_en), .cfg_wait_cnt(cfg_wait_cnt),
        .bus_area(bus_area), .bus_addr(bus_addr), .bus_as(bus_as), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
        .bus_din(bus_din), .bus_wait(bus_wait), .bus_tidle(bus_tidle)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Reference record of the last completed cycle
    bit m_last_rd   = 1'b0;
    int m_last_area = 0;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input string tag, input bit ok, input string act, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %s expected %s", tag, act, exp);
        end
    endtask

    task automatic quiet_cycle(input string tag);
        @(negedge clk);
        req = 1'b0;
        bus_wait = 1'b0;
        #1;
        check(tag, {ack, bus_as, bus_rd, bus_wr, bus_tidle, bus_dout_en} == 6'b0,
              $sformatf("ack/as/rd/wr/ti/oe=%b", {ack, bus_as, bus_rd, bus_wr, bus_tidle, bus_dout_en}),
              "000000");
    endtask

    task automatic access(input string tag, input int area, input int addr, input bit wr,
                          input bit burst, input int wdata, input int din, input int pinw);
        bit ins;
        int waits, total, lead;
        if (!m_last_rd)      ins = 1'b0;
        else if (wr)         ins = cfg_wr_idle_en;
        else                 ins = cfg_rr_idle_en && (area != m_last_area);
        waits = burst ? 0 : imax(int'(cfg_wait_cnt), pinw);
        lead  = ins ? 1 : 0;
        total = lead + (burst ? 1 : 2 + waits);
        for (int k = 0; k < total; k++) begin
            int p;
            bit e_ti, e_as, e_dat, e_ack;
            logic [5:0] got, exp;
            p     = k - lead;
            e_ti  = ins && (k == 0);
            e_as  = !burst && (p == 0);
            e_dat = (p >= 0) && (burst || p >= 1);
            e_ack = (k == total - 1);
            @(negedge clk);
            req       = 1'b1;
            req_area  = AREA_W'(area);
            req_addr  = ADDR_W'(addr);
            req_write = wr;
            req_burst = burst;
            req_wdata = DATA_W'(wdata);
            bus_din   = DATA_W'(din);
            if (burst) bus_wait = e_dat && (pinw > 0);
            else       bus_wait = e_dat && ((p - 1) < pinw);
            #1;
            got = {ack, bus_as, bus_rd, bus_wr, bus_tidle, bus_dout_en};
            exp = {e_ack, e_as, e_dat && !wr, e_dat && wr, e_ti, (e_as || e_dat) && wr};
            check(tag, got == exp, $sformatf("cyc%0d ack/as/rd/wr/ti/oe=%b", k, got),
                  $sformatf("%b", exp));
            if (e_as || e_dat) begin
                check("R12", (bus_area == AREA_W'(area)) && (bus_addr == ADDR_W'(addr)) &&
                      (!wr || bus_dout == DATA_W'(wdata)),
                      $sformatf("area=%0d addr=%h dout=%h", bus_area, bus_addr, bus_dout),
                      $sformatf("area=%0d addr=%h dout=%h", area, addr, wdata));
            end
        end
        m_last_rd   = !wr;
        m_last_area = area;
        bus_wait    = 1'b0;
        if (!wr) begin
            @(posedge clk);
            #1;
            check("R11", rd_data == DATA_W'(din), $sformatf("rd_data=%h", rd_data),
                  $sformatf("%h", DATA_W'(din)));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", {ack, bus_as, bus_rd, bus_wr, bus_tidle} == 5'b0 && rd_data == '0,
              $sformatf("%b rd=%h", {ack, bus_as, bus_rd, bus_wr, bus_tidle}, rd_data), "00000 rd=0");
        @(negedge clk);
        rst = 1'b0;
        quiet_cycle("R1");

        access("R1", 1, 16'h0100, 1'b0, 1'b0, 0, 16'hA001, 0);
        access("R3", 1, 16'h0104, 1'b0, 1'b0, 0, 16'hA002, 0);
        access("R2", 2, 16'h0200, 1'b0, 1'b0, 0, 16'hA003, 0);
        access("R5", 2, 16'h0208, 1'b1, 1'b0, 16'h5A5A, 0, 0);
        access("R7", 3, 16'h0300, 1'b1, 1'b0, 16'h1234, 0, 0);
        access("R7", 0, 16'h0010, 1'b0, 1'b0, 0, 16'hA004, 0);

        cfg_wait_cnt = 3'd2;
        access("R8", 0, 16'h0014, 1'b0, 1'b0, 0, 16'hA005, 0);
        access("R9", 0, 16'h0018, 1'b0, 1'b0, 0, 16'hA006, 4);
        cfg_wait_cnt = 3'd3;
        access("R9", 0, 16'h001C, 1'b0, 1'b0, 0, 16'hA007, 1);
        access("R8", 5, 16'h0500, 1'b1, 1'b0, 16'hBEEF, 0, 2);

        access("R10", 0, 16'h0020, 1'b0, 1'b0, 0, 16'hB000, 0);
        access("R10", 0, 16'h0022, 1'b0, 1'b1, 0, 16'hB001, 3);
        access("R10", 1, 16'h0024, 1'b0, 1'b1, 0, 16'hB002, 1);

        cfg_wait_cnt = 3'd0;
        cfg_rr_idle_en = 1'b0;
        access("R4", 2, 16'h0220, 1'b0, 1'b0, 0, 16'hC001, 0);
        cfg_wr_idle_en = 1'b0;
        access("R6", 2, 16'h0224, 1'b1, 1'b0, 16'h0F0F, 0, 0);

        cfg_rr_idle_en = 1'b1;
        cfg_wr_idle_en = 1'b1;
        access("R3", 3, 16'h0330, 1'b0, 1'b0, 0, 16'hC002, 0);
        quiet_cycle("R11");
        quiet_cycle("R11");
        access("R5", 4, 16'h0440, 1'b1, 1'b0, 16'h7777, 0, 0);
        access("R7", 4, 16'h0444, 1'b1, 1'b0, 16'h8888, 0, 0);

        access("R2", 6, 16'h0660, 1'b0, 1'b0, 0, 16'hD001, 0);
        @(negedge clk);
        req = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_last_rd = 1'b0;
        access("R1", 7, 16'h0770, 1'b0, 1'b0, 0, 16'hD002, 0);
        access("R1", 7, 16'h0774, 1'b1, 1'b0, 16'h9999, 0, 0);
        quiet_cycle("R11");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule